// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of a single read or write burst for a DDR2-style memory model or controller. A start strobe captures a start column, a burst length of four or eight beats and an ordering type, sequential or interleaved. The block then emits one column per clock cycle with a valid flag. A last flag marks the final beat.

All columns of a burst lie inside an aligned block that the start column selects. The block is four columns wide for length 4 and eight columns wide for length 8. The low bits of the start column only choose where the walk through that block begins. In sequential order at length 8, the walk wraps inside the current four-column half and then crosses to the other half. In interleaved order it follows an XOR pattern over all eight columns. The block contains no data path, bank or row handling, or command timing.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and until the internal reset has been released, valid_o, last_o and err_o are all 0.
- R2: A start_i sampled high while no burst is active starts a burst. Beat 0 is presented with valid_o high in the cycle after that clock edge. The remaining beats follow on consecutive cycles, for 8 beats in total when mode_bl8_i is 1 and 4 beats when it is 0. valid_o is 0 in the cycle after the final beat.
- R3: last_o is 1 exactly in the cycle of the final beat of a burst and is 0 at all other times.
- R4: For every beat, col_o bits from bit 2 upward (length 4) or from bit 3 upward (length 8) equal the same bits of the captured start column.
- R5: For length 4 with sequential order (mode_ilv_i = 0), col_o[1:0] on beat k equals (start[1:0] + k) mod 4.
- R6: With interleaved order (mode_ilv_i = 1), the low bits of col_o on beat k equal start XOR k, over bits [1:0] for length 4 and over bits [2:0] for length 8.
- R7: For length 8 with sequential order, col_o[1:0] on beat k equals (start[1:0] + k) mod 4, and col_o[2] equals start[2] XOR k[2]. For example, a start offset of 1 gives 1,2,3,0,5,6,7,4.
- R8: mode_bl8_i and mode_ilv_i are captured only when a burst starts. Changing them during a burst alters neither the order nor the length of that burst.
- R9: A start_i sampled high while a burst is active is ignored, and the running burst continues unchanged. err_o is 1 for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | Start column address |
| mode_bl8_i | input | 1 | Burst length select: 1 = eight beats, 0 = four beats |
| mode_ilv_i | input | 1 | Order select: 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of the burst |
| err_o | output | 1 | One-cycle flag for a start that was ignored |

## Verification
Each result has a fixed place in time after the clock edge that samples its stimulus. Beat 0, its column and valid_o appear in the first cycle after the accepting edge, and beat k appears k cycles later. err_o answers an ignored start in the cycle after the edge that sampled it. The bench drives inputs on the falling edge and reads outputs on the next falling edge. Every read therefore falls midway through the cycle in which the result is due. Each beat is checked on its own cycle against a column the bench computes from the ordering rules. A further check confirms that valid_o has dropped one cycle after the final beat.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
  localparam int unsigned BEAT_W = 3;
  localparam logic [BEAT_W-1:0] LAST_BL4 = 3'd3;
  localparam logic [BEAT_W-1:0] LAST_BL8 = 3'd7;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic                bl8_i,
  input  order_e              ord_i,
  output logic                busy_o,
  output logic [BEAT_W-1:0]   beat_o,
  output logic [COL_W-1:0]    base_o,
  output logic                bl8_o,
  output order_e              ord_o,
  output logic                last_o,
  output logic                err_o
);
  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0]  base_q, base_d;
  logic              bl8_q, bl8_d;
  order_e            ord_q, ord_d;
  logic              err_q, err_d;
  logic              accept;
  logic              at_last;
  logic              cfg_en;

  assign at_last = busy_q && (beat_q == (bl8_q ? LAST_BL8 : LAST_BL4));
  assign accept  = start_i && !busy_q;
  assign cfg_en  = accept;

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    err_d  = start_i && busy_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (busy_q) begin
      if (at_last) begin
        busy_d = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    base_d = base_q;
    bl8_d  = bl8_q;
    ord_d  = ord_q;
    if (cfg_en) begin
      base_d = start_col_i;
      bl8_d  = bl8_i;
      ord_d  = ord_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      bl8_q  <= 1'b0;
      ord_q  <= ORD_SEQ;
    end else begin
      base_q <= base_d;
      bl8_q  <= bl8_d;
      ord_q  <= ord_d;
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
  assign base_o = base_q;
  assign bl8_o  = bl8_q;
  assign ord_o  = ord_q;
  assign last_o = at_last;
  assign err_o  = err_q;

  // R2: an accepted start yields an active burst on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && beat_q == '0));
  // R2: a burst not at its final beat keeps running
  p_no_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> busy_q);
  // R3: the final beat ends the burst
  p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !start_i) |=> !busy_q);
  // R8: captured mode holds for the whole burst
  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> ($stable(bl8_q) && $stable(ord_q) && $stable(base_q)));
  // R9: a rejected start is flagged once
  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q) |=> err_q);
endmodule

// File: rtl/bcs_order.sv
module bcs_order
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic              bl8_i,
  input  order_e            ord_i,
  output logic [COL_W-1:0]  col_o
);
  localparam int unsigned HI_W = COL_W - BEAT_W;

  logic [1:0] nib_seq;
  logic [1:0] nib_ilv;
  logic       half_bit;
  logic [2:0] low3;

  assign nib_seq = base_i[1:0] + beat_i[1:0];
  assign nib_ilv = base_i[1:0] ^ beat_i[1:0];

  always_comb begin
    if (bl8_i) half_bit = base_i[2] ^ beat_i[2];
    else       half_bit = base_i[2];
    low3 = {half_bit, (ord_i == ORD_ILV) ? nib_ilv : nib_seq};
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign col_o = {base_i[COL_W-1:BEAT_W], low3};
    end else begin : g_nohi
      assign col_o = low3[COL_W-1:0];
    end
  endgenerate

  // R4: the low bits of the order never touch the upper block bits
  always_comb begin
    if (HI_W > 0)
      a_hi_kept_r4: assert (col_o[COL_W-1:BEAT_W] == base_i[COL_W-1:BEAT_W]);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             mode_bl8_i,
  input  logic             mode_ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic              rst_int_n;
  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base;
  logic              bl8_cap;
  order_e            ord_cap;
  order_e            ord_in;

  assign ord_in = mode_ilv_i ? ORD_ILV : ORD_SEQ;

  bcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  bcs_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .bl8_i       (mode_bl8_i),
    .ord_i       (ord_in),
    .busy_o      (busy),
    .beat_o      (beat),
    .base_o      (base),
    .bl8_o       (bl8_cap),
    .ord_o       (ord_cap),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  bcs_order #(.COL_W(COL_W)) u_ord (
    .base_i (base),
    .beat_i (beat),
    .bl8_i  (bl8_cap),
    .ord_i  (ord_cap),
    .col_o  (col_o)
  );

  assign valid_o = busy;

  // R3: last only on a valid beat
  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    last_o |-> valid_o);
  // R3: after the last beat the output goes idle
  p_idle_after_last_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (last_o && !start_i) |=> !valid_o);
  // R9: an error pulse follows a cycle in which a burst was running
  p_err_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |-> $past(valid_o));
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int COL_W = 10;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic             mode_bl8_i;
  logic             mode_ilv_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .mode_bl8_i(mode_bl8_i), .mode_ilv_i(mode_ilv_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input int k,
                                                input bit bl8, input bit ilv);
    int lo, hi, half;
    if (ilv) begin
      if (bl8) return (s & ~10'd7) | ((s & 7) ^ k);
      else     return (s & ~10'd3) | ((s & 3) ^ k);
    end
    lo = ((s & 3) + k) % 4;
    if (bl8) half = (((s >> 2) & 1) + (k / 4)) % 2;
    else     half = (s >> 2) & 1;
    hi = s & ~10'd7;
    return COL_W'(hi | (half << 2) | lo);
  endfunction

  // Accepts a burst at the next edge and checks every beat.
  // Optional: flip modes during the burst, or pulse start at beat 'poke'.
  task automatic burst(input string req, input logic [COL_W-1:0] s, input bit bl8,
                       input bit ilv, input bit flip, input int poke);
    int n;
    n = bl8 ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; mode_bl8_i = bl8; mode_ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
    if (flip) begin mode_bl8_i = ~bl8; mode_ilv_i = ~ilv; end
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, 32'(valid_o), 1);
      chk({req, " col"}, 32'(col_o), 32'(exp_col(s, k, bl8, ilv)));
      chk({req, " R3 last"}, 32'(last_o), (k == n - 1) ? 1 : 0);
      if (poke >= 0 && k == poke + 1) chk("R9 err pulse", 32'(err_o), 1);
      else                            chk("R9 err quiet", 32'(err_o), 0);
      if (k == poke) begin start_i = 1'b1; start_col_i = ~s; end
      else           start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk({req, " R2 idle after burst"}, 32'(valid_o), 0);
    chk({req, " R3 last idle"}, 32'(last_o), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; mode_bl8_i = 1'b0; mode_ilv_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(valid_o), 0);
    chk("R1 last in reset", 32'(last_o), 0);
    chk("R1 err in reset", 32'(err_o), 0);
    rst_n = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    chk("R1 valid during sync", 32'(valid_o), 0);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", 32'(valid_o), 0);
  endtask

  task automatic t_bl4_seq;
    burst("R5 R4 bl4 seq s=0", 10'h000, 1'b0, 1'b0, 1'b0, -1);
    burst("R5 R4 bl4 seq s=2", 10'h2B6, 1'b0, 1'b0, 1'b0, -1);
    burst("R5 R4 bl4 seq s=3", 10'h3FF, 1'b0, 1'b0, 1'b0, -1);
  endtask

  task automatic t_ilv;
    burst("R6 bl4 ilv", 10'h1A5, 1'b0, 1'b1, 1'b0, -1);
    burst("R6 bl8 ilv s=3", 10'h0F3, 1'b1, 1'b1, 1'b0, -1);
    burst("R6 bl8 ilv s=6", 10'h2CE, 1'b1, 1'b1, 1'b0, -1);
  endtask

  task automatic t_bl8_seq;
    burst("R7 R2 bl8 seq s=1", 10'h001, 1'b1, 1'b0, 1'b0, -1);
    burst("R7 R4 bl8 seq s=6", 10'h356, 1'b1, 1'b0, 1'b0, -1);
  endtask

  task automatic t_mode_change;
    burst("R8 flip bl8 seq", 10'h105, 1'b1, 1'b0, 1'b1, -1);
    burst("R8 flip bl4 ilv", 10'h20A, 1'b0, 1'b1, 1'b1, -1);
  endtask

  task automatic t_busy_start;
    burst("R9 start mid bl8", 10'h0C2, 1'b1, 1'b0, 1'b0, 2);
    burst("R9 start at last bl4", 10'h311, 1'b0, 1'b1, 1'b0, 3);
    @(negedge clk);
    chk("R9 err quiet after", 32'(err_o), 0);
  endtask

  initial begin
    t_reset();
    t_bl4_seq();
    t_ilv();
    t_bl8_seq();
    t_mode_change();
    t_busy_start();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule